// File: doc/BRIEF.md
# Multiple-Input Signature Register

This block compacts the parallel outputs of a circuit under test into one signature. It is a modular (internal-XOR) LFSR of `WIDTH` stages. On every enabled clock, each stage takes its lower neighbour, adds the feedback from the top stage where the tap polynomial has a term, and adds its own data line. The block is linear, so the final value equals the XOR of the remainders that one serial divider per output line would leave. One register therefore replaces one divider per line.

A clear input seeds the register with zeros before a test starts. After the last pattern, the test controller raises `done_i`. The match output then reports whether the held signature equals the golden value. A parameter selects the golden source: either the `gold_i` port or the constant `GOLD_SIG`. Computing the golden value and driving the circuit under test are left to the surrounding logic.

Top module: `misr_sig`

## Requirements
- R1: While `rst_ni` is low, `sig_o` is all zeros, regardless of the other inputs.
- R2: A rising clock edge with `clr_i` high loads all zeros into the register, even when `en_i` is also high.
- R3: A rising clock edge with `clr_i` low and `en_i` low leaves `sig_o` unchanged, whatever `data_i` carries.
- R4: A rising clock edge with `clr_i` low and `en_i` high loads the following values, where X is the old value and `TAPS[i]` is the coefficient of x^i: stage 0 takes X[WIDTH-1] ^ `data_i`[0], and stage i≥1 takes X[i-1] ^ (`TAPS[i]` & X[WIDTH-1]) ^ `data_i`[i]. `TAPS[0]` is not used.
- R5: Starting from the zero seed, the signature of a word sequence A^B equals the XOR of the signatures of A and of B.
- R6: `match_o` is combinational. It is 1 exactly when `done_i` is high and `sig_o` equals the golden value.
- R7: With `GOLD_FROM_PORT` = 0, the golden value is the parameter `GOLD_SIG`, and `gold_i` has no effect on `match_o`.
- R8: A 3-stage instance with `TAPS` = 3'b010 computes stage0 = X2^d0, stage1 = X0^X2^d1 and stage2 = X1^d2. Starting from zero, the inputs 3'b100, 0, 0 give the signatures 3'b100, 3'b011 and 3'b110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous seed to zero |
| en_i | input | 1 | Compaction enable |
| data_i | input | WIDTH | Parallel response lines from the circuit under test |
| gold_i | input | WIDTH | Golden signature (used when GOLD_FROM_PORT = 1) |
| done_i | input | 1 | Qualifies the comparison |
| sig_o | output | WIDTH | Current signature |
| match_o | output | 1 | Signature equals the golden value while done |

## Verification
The assertions check every cycle that clear leaves zeros, that an idle cycle keeps the register stable, that stage 0 follows the top stage XOR its data line, and that the match output stays low without done. Only the bench scenarios can show the following. The full signature agrees with a polynomial-division model across mixed clear, hold and shift cycles. Superposition holds for whole sequences. The hand-worked 3-stage signatures come out right. A parameter-selected golden value ignores the port.

// File: rtl/misr_pkg.sv
package misr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_SHIFT = 2'd2
  } misr_op_e;
endpackage

// File: rtl/misr_ctl.sv
module misr_ctl
  import misr_pkg::*;
(
  input  logic     clr_i,
  input  logic     en_i,
  output misr_op_e op_o
);
  // clear wins over enable
  always_comb begin
    if (clr_i)     op_o = OP_CLEAR;
    else if (en_i) op_o = OP_SHIFT;
    else           op_o = OP_HOLD;
  end
endmodule

// File: rtl/misr_stage.sv
module misr_stage
  import misr_pkg::*;
#(
  parameter bit USE_FB = 1'b0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  misr_op_e op_i,
  input  logic     prev_i,
  input  logic     fb_i,
  input  logic     d_i,
  output logic     q_o
);
  logic fb_term;

  generate
    if (USE_FB) begin : g_tap
      assign fb_term = fb_i;
    end else begin : g_notap
      logic unused_fb;
      assign unused_fb = fb_i;
      assign fb_term   = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
    end else begin
      case (op_i)
        OP_CLEAR: q_o <= 1'b0;
        OP_SHIFT: q_o <= prev_i ^ fb_term ^ d_i;
        default:  q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/misr_reg.sv
module misr_reg
  import misr_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'b0001_1100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  misr_op_e         op_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] sig_o
);
  localparam int unsigned TOP = WIDTH - 1;

  logic msb;
  assign msb = sig_o[TOP];

  // stage 0 always receives the top stage: the x^0 term of g(x)
  misr_stage #(.USE_FB(1'b0)) i_stage0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op_i),
    .prev_i (msb),
    .fb_i   (1'b0),
    .d_i    (data_i[0]),
    .q_o    (sig_o[0])
  );

  for (genvar i = 1; i < WIDTH; i++) begin : g_stage
    misr_stage #(.USE_FB(TAPS[i])) i_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .op_i   (op_i),
      .prev_i (sig_o[i-1]),
      .fb_i   (msb),
      .d_i    (data_i[i]),
      .q_o    (sig_o[i])
    );
  end

  AST_STAGE0_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHIFT) |=> sig_o[0] == ($past(sig_o[TOP]) ^ $past(data_i[0])))
    else $error("stage0 wrap"); // R4
endmodule

// File: rtl/misr_cmp.sv
module misr_cmp #(
  parameter int unsigned WIDTH = 8,
  parameter bit GOLD_FROM_PORT = 1'b1,
  parameter logic [WIDTH-1:0] GOLD_SIG = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sig_i,
  input  logic [WIDTH-1:0] gold_i,
  input  logic             done_i,
  output logic             match_o
);
  logic [WIDTH-1:0] gold_sel;

  generate
    if (GOLD_FROM_PORT) begin : g_port
      assign gold_sel = gold_i;
    end else begin : g_param
      logic [WIDTH-1:0] unused_gold;
      assign unused_gold = gold_i;
      assign gold_sel    = GOLD_SIG;
    end
  endgenerate

  assign match_o = done_i && (sig_i == gold_sel);

  AST_MATCH_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> !match_o) else $error("match without done"); // R6
endmodule

// File: rtl/misr_sig.sv
module misr_sig
  import misr_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'b0001_1100,
  parameter bit GOLD_FROM_PORT = 1'b1,
  parameter logic [WIDTH-1:0] GOLD_SIG = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] gold_i,
  input  logic             done_i,
  output logic [WIDTH-1:0] sig_o,
  output logic             match_o
);
  misr_op_e op;

  misr_ctl i_ctl (
    .clr_i (clr_i),
    .en_i  (en_i),
    .op_o  (op)
  );

  misr_reg #(.WIDTH(WIDTH), .TAPS(TAPS)) i_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .data_i (data_i),
    .sig_o  (sig_o)
  );

  misr_cmp #(.WIDTH(WIDTH), .GOLD_FROM_PORT(GOLD_FROM_PORT), .GOLD_SIG(GOLD_SIG)) i_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sig_i   (sig_o),
    .gold_i  (gold_i),
    .done_i  (done_i),
    .match_o (match_o)
  );

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> sig_o == '0) else $error("clear not zero"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(sig_o)) else $error("idle changed"); // R3
endmodule

// File: tb/test_misr_sig.sv
module test_misr_sig;
  localparam int unsigned W = 8;
  localparam logic [W-1:0] TP = 8'b0001_1100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, en = 1'b0, done = 1'b0;
  logic [W-1:0] data = '0, gold = '0;
  logic [2:0] d3 = '0;
  logic [W-1:0] sig, sig_p;
  logic [2:0] sig3;
  logic match, match_p, match3;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] model = '0;

  always #4 clk = ~clk;

  misr_sig #(.WIDTH(W), .TAPS(TP)) i_misr_sig (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_i(en), .data_i(data),
    .gold_i(gold), .done_i(done), .sig_o(sig), .match_o(match));

  misr_sig #(.WIDTH(W), .TAPS(TP), .GOLD_FROM_PORT(1'b0), .GOLD_SIG(8'hA5)) i_misr_par (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_i(en), .data_i(data),
    .gold_i(gold ^ 8'hFF), .done_i(done), .sig_o(sig_p), .match_o(match_p));

  misr_sig #(.WIDTH(3), .TAPS(3'b010)) i_misr_3 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_i(en), .data_i(d3),
    .gold_i(3'b000), .done_i(1'b0), .sig_o(sig3), .match_o(match3));

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // polynomial-division view: shift up, reduce by g(x) when x^W falls out
  function automatic logic [W-1:0] div_step(input logic [W-1:0] s, input logic [W-1:0] d);
    logic [W-1:0] g;
    g = TP | 1;
    return (s << 1) ^ (s[W-1] ? g : '0) ^ d;
  endfunction

  task automatic step(input logic c, input logic e, input logic [W-1:0] d);
    string req;
    @(negedge clk);
    clr = c; en = e; data = d;
    if (c) begin model = '0; req = "R2"; end
    else if (e) begin model = div_step(model, d); req = "R4"; end
    else req = "R3";
    @(posedge clk); #1;
    chk(sig == model, req, sig, model);
  endtask

  task automatic run_seq(input int kind, output logic [W-1:0] res);
    step(1'b1, 1'b0, '0);
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] a, b, v;
      a = W'(k * 37 + 5);
      b = W'(k * 91 + 202);
      v = (kind == 0) ? a : (kind == 1) ? b : (a ^ b);
      step(1'b0, 1'b1, v);
    end
    res = sig;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    join_none
  end

  initial begin
    logic [W-1:0] sa, sb, sab;
    // R1: reset holds zero despite active inputs
    en = 1'b1; data = 8'hFF;
    repeat (3) @(posedge clk);
    #1 chk(sig == '0, "R1", sig, '0);
    @(negedge clk); en = 1'b0; data = '0; rst_n = 1'b1;
    @(posedge clk); #1 chk(sig == '0, "R1", sig, '0);

    // R4 / R3 / R2 mixed traffic against the model
    for (int k = 0; k < 40; k++) step(1'b0, (k % 5) != 3, W'(k * 29 + 7));
    step(1'b0, 1'b0, 8'h5A);   // R3: data ignored while idle
    step(1'b0, 1'b0, 8'hC3);   // R3
    step(1'b1, 1'b1, 8'hFF);   // R2: clear beats enable
    for (int k = 0; k < 12; k++) step(1'b0, 1'b1, (k == 0) ? 8'h80 : 8'h00);
    step(1'b1, 1'b0, '0);

    // R6 / R7: one shift of A5 from zero
    step(1'b0, 1'b1, 8'hA5);
    @(negedge clk); en = 1'b0; gold = 8'hA5; done = 1'b0; #1;
    chk(match == 1'b0, "R6", W'(match), '0);
    done = 1'b1; #1;
    chk(match == 1'b1, "R6", W'(match), 1);
    chk(match_p == 1'b1, "R7", W'(match_p), 1);
    gold = 8'hA4; #1;
    chk(match == 1'b0, "R6", W'(match), '0);
    chk(match_p == 1'b1, "R7", W'(match_p), 1);
    gold = 8'hA5; #1;
    chk(match_p == 1'b1, "R7", W'(match_p), 1);
    step(1'b0, 1'b1, 8'h01);
    #1 chk(match_p == 1'b0, "R7", W'(match_p), '0);
    @(negedge clk); done = 1'b0;

    // R8: 3-stage worked example
    step(1'b1, 1'b0, '0);
    d3 = 3'b100;
    step(1'b0, 1'b1, '0);
    chk(sig3 == 3'b100, "R8", W'(sig3), 8'h04);
    d3 = 3'b000;
    step(1'b0, 1'b1, '0);
    chk(sig3 == 3'b011, "R8", W'(sig3), 8'h03);
    step(1'b0, 1'b1, '0);
    chk(sig3 == 3'b110, "R8", W'(sig3), 8'h06);

    // R5: superposition across whole sequences
    run_seq(0, sa);
    run_seq(1, sb);
    run_seq(2, sab);
    chk(sab == (sa ^ sb), "R5", sab, sa ^ sb);
    chk(sa != sb, "R5", sa, sb);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule